// File: doc/BRIEF.md
# Serial Display Register Writer

This block loads a 16-bit value into an indexed register of an external display controller. The link is three wires and runs one way only: an active-low chip select, a serial clock and a serial data line. A request carries an 8-bit register index and a 16-bit value. The block performs the whole write without further help and reports progress through `busy` and a one-cycle `done` pulse.

Each write is made of two frames, each framed by its own chip-select window. The first frame holds a start byte, a zero byte and the register index. The second frame holds the start byte with its register-select bit set, followed by the value, upper byte first. Every bit is paced by a programmable step length counted in system clocks. Within a bit, the clock goes low, the data line is updated and the clock goes high, with one step between each of these actions. Chip select has one step of setup before the first clock edge and one step of hold after the last one.

Top module: `disp_reg_writer`

## Requirements
- R1: After reset and whenever idle, chip select and serial clock are high, serial data is low, and `busy` and `done` are low.
- R2: A request (`req_valid` high for a cycle) starts a write only while `busy` is low. A request made while `busy` is high is dropped and produces no frame.
- R3: The first frame carries exactly 24 bits: start byte 0x74, then 0x00, then the register index.
- R4: The second frame carries exactly 24 bits: start byte 0x76 (register-select bit, value 0x02, set), then value bits 15..8, then bits 7..0. The read/write bit (value 0x01) of every start byte is zero.
- R5: Bits leave most significant first. The receiver samples on the rising edge of the serial clock.
- R6: Serial data changes only while the serial clock is low. Each low period lasts 2 steps: one before the data update and one after it. The high period between two bits lasts 1 step.
- R7: Chip select falls 1 step before the first falling clock edge and rises 1 step after the last rising clock edge, so a frame's chip-select window lasts 73 steps. The clock is high whenever chip select changes, and the clock never goes low while chip select is high.
- R8: The two frames of a write are separated by a chip-select high time of exactly 1 step.
- R9: `done` is a single-cycle pulse that occurs one cycle after chip select rises at the end of the second frame. `busy` falls 1 step after that rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a write (taken only while idle) |
| req_index | input | INDEX_W (8) | Controller register index |
| req_value | input | VALUE_W (16) | Value to write |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse at the end of a write |

## Verification
If the bit counter or the phase flag goes wrong, the result shows up as frames of the wrong length. It can also appear as a missing or repeated second frame, or a wrong start byte. All of these are visible at the next chip-select rise, at most 73 steps later. A fault in the pacer or in the state sequence changes the clock low or high times, the setup time, the hold time or the gap between frames. The bench measures these in cycles within one bit period. A shifter that is loaded or advanced at the wrong point gives wrong decoded bytes. It can also move the data line while the clock is high, which the bench catches on the same step.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;

    // Start-byte control bits, decoded by the receiving controller
    localparam logic [7:0] HDR_SEL_MASK = 8'h02;  // set: value phase
    localparam logic [7:0] HDR_RW_MASK  = 8'h01;  // always cleared: write

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CS_ON  = 3'd1,
        ST_CLK_LO = 3'd2,
        ST_DATA   = 3'd3,
        ST_CLK_HI = 3'd4,
        ST_CS_OFF = 3'd5
    } wr_state_e;

endpackage

// File: rtl/disp_spi_pacer.sv
module disp_spi_pacer #(
    parameter int STEP_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic step_first,
    output logic step_last
);
    localparam int CW = $clog2(STEP_CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = TOP;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign step_first = (cnt_q == TOP);
    assign step_last  = (cnt_q == '0);
endmodule

// File: rtl/disp_spi_shifter.sv
module disp_spi_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift,
    output logic             msb
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)
            sr_d = load_word;
        else if (shift)
            sr_d = {sr_q[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[WIDTH-1];
endmodule

// File: rtl/disp_reg_writer.sv
module disp_reg_writer
    import disp_spi_pkg::*;
#(
    parameter int         STEP_CYCLES = 100,
    parameter int         INDEX_W     = 8,
    parameter int         VALUE_W     = 16,
    parameter logic [7:0] START_ID    = 8'h74
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [INDEX_W-1:0] req_index,
    input  logic [VALUE_W-1:0] req_value,
    output logic               spi_cs_n,
    output logic               spi_sclk,
    output logic               spi_sdo,
    output logic               busy,
    output logic               done
);
    localparam int FRAME_W = 8 + VALUE_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);
    localparam logic [7:0] HDR_INDEX = START_ID & ~HDR_SEL_MASK & ~HDR_RW_MASK;
    localparam logic [7:0] HDR_VALUE = (START_ID | HDR_SEL_MASK) & ~HDR_RW_MASK;

    typedef struct packed {
        wr_state_e          st;
        logic               phase;    // 0: index frame, 1: value frame
        logic [IDX_W-1:0]   bit_idx;
        logic [VALUE_W-1:0] val;
        logic               cs_n;
        logic               sclk;
        logic               sdo;
        logic               done;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    logic               step_first, step_last, restart;
    logic               sh_load, sh_shift, sh_msb;
    logic [FRAME_W-1:0] sh_word;

    disp_spi_pacer #(.STEP_CYCLES(STEP_CYCLES)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step_first (step_first),
        .step_last  (step_last)
    );

    disp_spi_shifter #(.WIDTH(FRAME_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_word),
        .shift     (sh_shift),
        .msb       (sh_msb)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_word  = '0;
        restart  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st      = ST_CS_ON;
                    r_d.cs_n    = 1'b0;
                    r_d.phase   = 1'b0;
                    r_d.bit_idx = '0;
                    r_d.val     = req_value;
                    sh_load     = 1'b1;
                    sh_word     = {HDR_INDEX, VALUE_W'(req_index)};
                    restart     = 1'b1;
                end
            end
            ST_CS_ON: begin
                if (step_last) begin
                    r_d.st   = ST_CLK_LO;
                    r_d.sclk = 1'b0;
                    restart  = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (step_last) begin
                    r_d.st  = ST_DATA;
                    r_d.sdo = sh_msb;
                    restart = 1'b1;
                end
            end
            ST_DATA: begin
                if (step_last) begin
                    r_d.st   = ST_CLK_HI;
                    r_d.sclk = 1'b1;
                    sh_shift = 1'b1;
                    restart  = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (step_last) begin
                    restart = 1'b1;
                    if (r_q.bit_idx == LAST_BIT) begin
                        r_d.st   = ST_CS_OFF;
                        r_d.cs_n = 1'b1;
                    end else begin
                        r_d.st      = ST_CLK_LO;
                        r_d.sclk    = 1'b0;
                        r_d.bit_idx = r_q.bit_idx + IDX_W'(1);
                    end
                end
            end
            ST_CS_OFF: begin
                if (step_first && r_q.phase)
                    r_d.done = 1'b1;
                if (step_last) begin
                    restart = 1'b1;
                    if (!r_q.phase) begin
                        r_d.st      = ST_CS_ON;
                        r_d.cs_n    = 1'b0;
                        r_d.phase   = 1'b1;
                        r_d.bit_idx = '0;
                        sh_load     = 1'b1;
                        sh_word     = {HDR_VALUE, r_q.val};
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.sdo = 1'b0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.cs_n    <= 1'b1;
            r_q.sclk    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_cs_n = r_q.cs_n;
    assign spi_sclk = r_q.sclk;
    assign spi_sdo  = r_q.sdo;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
endmodule

// File: rtl/disp_reg_writer_chk.sv
module disp_reg_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_sdo,
    input logic busy,
    input logic done
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && spi_sclk && !done));

    p_start_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_sdo_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk) && !spi_cs_n) |-> $stable(spi_sdo));

    p_cs_edge_clk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> spi_sclk);

    p_clk_low_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sclk |-> !spi_cs_n);

    p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind disp_reg_writer disp_reg_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_sdo   (spi_sdo),
    .busy      (busy),
    .done      (done)
);

// File: tb/disp_reg_writer_test.sv
module disp_reg_writer_test;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_value = '0;
    logic        spi_cs_n, spi_sclk, spi_sdo, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    disp_reg_writer #(.STEP_CYCLES(S)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_index(req_index), .req_value(req_value),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo),
        .busy(busy), .done(done)
    );

    // ---------------- line monitor (samples on falling clock edge) ----------
    int cyc = 0;
    logic p_cs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0, p_busy = 1'b0;
    logic [23:0] shreg = '0;
    logic [23:0] fword [0:7];
    int fbits [0:7];
    int flen  [0:7];
    int fhold [0:7];
    int fgap  [0:7];
    int nfr = 0, nbits = 0;
    int cs_fall_c = 0, cs_rise_c = 0, last_rise_c = 0, sclk_fall_c = 0;
    int first_pending = 0, setup_len = 0;
    int low_min = 9999, low_max = 0, hi_min = 9999, hi_max = 0;
    int sdo_viol = 0, done_cnt = 0, done_dly = -1, busy_dly = -1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (p_cs && !spi_cs_n) begin
                if (nfr < 8) fgap[nfr] = cyc - cs_rise_c;
                cs_fall_c = cyc; nbits = 0; first_pending = 1;
            end
            if (p_sclk && !spi_sclk) begin
                if (first_pending) setup_len = cyc - cs_fall_c;
                else begin
                    if (cyc - last_rise_c < hi_min) hi_min = cyc - last_rise_c;
                    if (cyc - last_rise_c > hi_max) hi_max = cyc - last_rise_c;
                end
                first_pending = 0; sclk_fall_c = cyc;
            end
            if (!p_sclk && spi_sclk) begin
                shreg = {shreg[22:0], spi_sdo};
                nbits = nbits + 1; last_rise_c = cyc;
                if (cyc - sclk_fall_c < low_min) low_min = cyc - sclk_fall_c;
                if (cyc - sclk_fall_c > low_max) low_max = cyc - sclk_fall_c;
            end
            if (spi_sclk && p_sclk && !spi_cs_n && spi_sdo != p_sdo)
                sdo_viol = sdo_viol + 1;
            if (!p_cs && spi_cs_n) begin
                if (nfr < 8) begin
                    fword[nfr] = shreg; fbits[nfr] = nbits;
                    flen[nfr] = cyc - cs_fall_c; fhold[nfr] = cyc - last_rise_c;
                end
                nfr = nfr + 1; cs_rise_c = cyc;
            end
            if (done) begin done_cnt = done_cnt + 1; done_dly = cyc - cs_rise_c; end
            if (p_busy && !busy) busy_dly = cyc - cs_rise_c;
        end
        p_cs = spi_cs_n; p_sclk = spi_sclk; p_sdo = spi_sdo; p_busy = busy;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nfr = 0; done_cnt = 0; done_dly = -1; busy_dly = -1; sdo_viol = 0;
        low_min = 9999; low_max = 0; hi_min = 9999; hi_max = 0;
    endtask

    task automatic pulse_req(input logic [7:0] idx, input logic [15:0] val);
        req_index = idx; req_value = val; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_idle_lines(input string tag);
        check({tag, " R1 cs_n"}, int'(spi_cs_n), 1);
        check({tag, " R1 sclk"}, int'(spi_sclk), 1);
        check({tag, " R1 sdo"},  int'(spi_sdo), 0);
        check({tag, " R1 busy"}, int'(busy), 0);
        check({tag, " R1 done"}, int'(done), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle_lines("reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle_lines("after reset");
    endtask

    task automatic t_write(input logic [7:0] idx, input logic [15:0] val);
        clear_mon();
        @(negedge clk);
        pulse_req(idx, val);
        check("R2 busy after accept", int'(busy), 1);
        wait_idle();
        check("R2 frame count", nfr, 2);
        check("R3 index frame bits", fbits[0], 24);
        check("R3 index frame start byte", int'(fword[0][23:16]), 8'h74);
        check("R3 index frame pad byte", int'(fword[0][15:8]), 8'h00);
        check("R5 index byte msb first", int'(fword[0][7:0]), int'(idx));
        check("R4 value frame bits", fbits[1], 24);
        check("R4 value frame start byte", int'(fword[1][23:16]), 8'h76);
        check("R4 read/write bit clear", int'(fword[1][16]), 0);
        check("R4 value high byte", int'(fword[1][15:8]), int'(val[15:8]));
        check("R4 value low byte", int'(fword[1][7:0]), int'(val[7:0]));
        check("R6 sdo still while sclk high", sdo_viol, 0);
        check("R6 sclk low min", low_min, 2 * S);
        check("R6 sclk low max", low_max, 2 * S);
        check("R6 sclk high min", hi_min, S);
        check("R6 sclk high max", hi_max, S);
        check("R7 setup to first fall", setup_len, S);
        check("R7 hold after last rise", fhold[1], S);
        check("R7 index frame window", flen[0], 73 * S);
        check("R7 value frame window", flen[1], 73 * S);
        check("R8 gap between frames", fgap[1], S);
        check("R9 done count", done_cnt, 1);
        check("R9 done delay", done_dly, 1);
        check("R9 busy fall delay", busy_dly, S);
        check_idle_lines("post write");
    endtask

    task automatic t_ignore_busy();
        clear_mon();
        @(negedge clk);
        pulse_req(8'h3C, 16'h1234);
        repeat (40) @(negedge clk);
        pulse_req(8'hC3, 16'hFEDC);     // mid index frame
        repeat (240) @(negedge clk);
        pulse_req(8'h99, 16'h8001);     // mid value frame
        wait_idle();
        repeat (30) @(negedge clk);
        check("R2 frames with busy requests", nfr, 2);
        check("R2 index unchanged", int'(fword[0][7:0]), 8'h3C);
        check("R2 value unchanged", int'(fword[1][15:0]), 16'h1234);
        check("R2 single done", done_cnt, 1);
        check("R2 stays idle", int'(busy), 0);
    endtask

    task automatic t_back_to_back();
        clear_mon();
        @(negedge clk);
        pulse_req(8'h01, 16'h0F0F);
        wait_idle();
        pulse_req(8'h80, 16'hF0F0);
        wait_idle();
        check("R2 back to back frames", nfr, 4);
        check("R5 second index", int'(fword[2][7:0]), 8'h80);
        check("R4 second value", int'(fword[3][15:0]), 16'hF0F0);
        check("R9 two dones", done_cnt, 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write(8'h01, 16'hA55A);
        t_write(8'h80, 16'h0001);
        t_write(8'hFF, 16'hFFFF);
        t_write(8'h00, 16'h0000);
        t_ignore_busy();
        t_back_to_back();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule